// File: doc/BRIEF.md
# Serial Negative-Multiple Window Generator

This block builds the comparison constants of a parallel quotient-digit estimator while the modulus is loaded. The modulus arrives one bit per clock, least significant bit first. A chain of bit-serial subtractor stages forms the two's complement values −j·m for j = 1 to N_MULT (39 by default). Each stage uses one full adder, one carry flip-flop and a one-cycle delay towards the next stage. Every stage keeps only a 12-digit window of its result, starting at bit position WIN_LO. The top digit of the window carries the sign. Because the lower bits are simply dropped, a window equals floor(−j·m / 2^WIN_LO) mod 2^12. The windows then serve as the estimator's constant registers.

A load begins with a start pulse. After that, modulus bits are accepted on cycles where the valid strobe is high, and the final bit is flagged by the last strobe. If the modulus is shorter than the window top, the block pads the stream with zero bits on its own. When the deepest stage has captured its top window bit, the done flag rises. The windows keep their values until the next start.

The control is a state machine with five states. IDLE is the state after reset. LOAD accepts modulus bits. PAD generates zero extension bits. FLUSH waits for the pipeline to drain. DONE holds the result. The transitions are as follows:
- Any state goes to LOAD on start.
- LOAD goes to PAD on the final bit when that bit lies below position WIN_LO+11.
- LOAD goes to FLUSH on the final bit otherwise.
- PAD goes to FLUSH once it has emitted bit WIN_LO+11.
- FLUSH goes to DONE once the deepest stage has emitted bit WIN_LO+11.

Top module: `negmul_window_gen`

## Requirements
- R1: After reset, done is 0 and every window in win reads zero.
- R2: After a load, window j occupies win bits [(j−1)·12 +: 12] and equals bits WIN_LO..WIN_LO+11 of the two's complement of −j·m, which is floor(−j·m / 2^WIN_LO) mod 4096, for every j from 1 to N_MULT.
- R3: Modulus bits are taken least significant first, only on cycles where m_valid is high. Cycles with m_valid low between bits are ignored, whatever m_bit holds.
- R4: The final modulus bit is the one that comes with m_last, or else the MOD_W-th accepted bit. A modulus shorter than WIN_LO+12 bits is zero-extended.
- R5: Modulus bits at positions above WIN_LO+11 have no effect on any window.
- R6: Once done has risen, done stays 1 and win stays unchanged until the next m_start.
- R7: m_start in any state, including in the middle of a load, clears done and every window on the next cycle and begins a new load.
- R8: m_bit, m_valid and m_last have no effect while done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_bit | input | 1 | Serial modulus bit, least significant first |
| m_valid | input | 1 | m_bit carries a modulus bit this cycle |
| m_start | input | 1 | Begin a new load; clears the results |
| m_last | input | 1 | Marks the final modulus bit (with m_valid) |
| done | output | 1 | All windows are captured |
| win | output | N_MULT·WIN_W | Packed windows, window j at bits [(j−1)·WIN_W +: WIN_W] |

## Verification
Two cases are hard to reach from the ports. One is a stream that never presents some window bits, which happens when the modulus ends below the window top. The other is a stream that carries bits past the window top, which happens when the modulus is longer than the window top and its last bit comes from the length count rather than m_last. The stimulus table covers both: a 16-bit modulus that forces the PAD state, and two 28-bit moduli that end without m_last and share their low 24 bits, so their windows must match. Some vectors insert idle cycles with a toggling m_bit between valid bits, and a second start arrives partway through a load.

// File: rtl/negmul_pkg.sv
package negmul_pkg;

    // Control states of the serial load sequencer
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_PAD   = 3'd2,
        ST_FLUSH = 3'd3,
        ST_DONE  = 3'd4
    } feed_state_t;

    // Carry-out of a single-bit full adder
    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/negmul_feed.sv
module negmul_feed
    import negmul_pkg::*;
#(
    parameter int MOD_W = 24,
    parameter int TOP   = 24,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_bit,
    input  logic          m_valid,
    input  logic          m_start,
    input  logic          m_last,
    input  logic          tail_hit,
    output logic          bit_o,
    output logic          vld_o,
    output logic [CW-1:0] idx_o,
    output logic          done_o
);

    localparam int              SPAN    = (MOD_W > TOP) ? MOD_W : TOP;
    localparam logic [CW-1:0]   TOP_C   = CW'(TOP);
    localparam logic [CW-1:0]   TOP_M1  = CW'(TOP - 1);
    localparam logic [CW-1:0]   MODW_M1 = CW'(MOD_W - 1);
    localparam logic [CW-1:0]   CNT_MAX = CW'(SPAN);

    feed_state_t   st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          tail_q;
    logic          last_now;

    assign last_now = m_last || (cnt_q == MODW_M1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (m_start) begin
            st_d = ST_LOAD;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_LOAD:  if (m_valid && last_now)
                              st_d = (cnt_q < TOP_M1) ? ST_PAD : ST_FLUSH;
                ST_PAD:   if (cnt_q == TOP_M1) st_d = ST_FLUSH;
                ST_FLUSH: if (tail_hit || tail_q) st_d = ST_DONE;
                ST_DONE:  st_d = ST_DONE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // Outputs: serial stream towards the stage chain and the done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tail_q <= 1'b0;
            bit_o  <= 1'b0;
            vld_o  <= 1'b0;
            idx_o  <= '0;
            done_o <= 1'b0;
        end else begin
            vld_o  <= 1'b0;
            bit_o  <= 1'b0;
            done_o <= (st_d == ST_DONE);
            if (m_start) begin
                cnt_q  <= '0;
                tail_q <= 1'b0;
            end else begin
                if (tail_hit) tail_q <= 1'b1;
                unique case (st_q)
                    ST_LOAD: begin
                        if (m_valid) begin
                            if (cnt_q < TOP_C) begin
                                vld_o <= 1'b1;
                                bit_o <= m_bit;
                                idx_o <= cnt_q;
                            end
                            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_PAD: begin
                        vld_o <= 1'b1;
                        bit_o <= 1'b0;
                        idx_o <= cnt_q;
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ST_IDLE, ST_FLUSH, ST_DONE: begin
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/negmul_stage.sv
module negmul_stage
    import negmul_pkg::*;
#(
    parameter int CW     = 5,
    parameter int WIN_LO = 12,
    parameter int WIN_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             a_i,
    input  logic             b_i,
    input  logic             v_i,
    input  logic [CW-1:0]    idx_i,
    output logic             sum_o,
    output logic             b_o,
    output logic             v_o,
    output logic [CW-1:0]    idx_o,
    output logic [WIN_W-1:0] win_o
);

    localparam logic [CW-1:0] LO_C = CW'(WIN_LO);
    localparam logic [CW-1:0] HI_C = CW'(WIN_LO + WIN_W - 1);

    logic carry_q;
    logic nb, cin, sum_d, cout_d, in_win;

    // Subtract: a + ~b + 1, the +1 entering as carry on bit 0
    assign nb     = ~b_i;
    assign cin    = (idx_i == '0) ? 1'b1 : carry_q;
    assign sum_d  = a_i ^ nb ^ cin;
    assign cout_d = fa_carry(a_i, nb, cin);
    assign in_win = (idx_i >= LO_C) && (idx_i <= HI_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            sum_o   <= 1'b0;
            b_o     <= 1'b0;
            v_o     <= 1'b0;
            idx_o   <= '0;
            win_o   <= '0;
        end else if (clr) begin
            carry_q <= 1'b0;
            v_o     <= 1'b0;
            win_o   <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                sum_o   <= sum_d;
                b_o     <= b_i;
                idx_o   <= idx_i;
                carry_q <= cout_d;
                if (in_win) win_o <= {sum_d, win_o[WIN_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/negmul_window_gen.sv
module negmul_window_gen
    import negmul_pkg::*;
#(
    parameter int MOD_W  = 24,
    parameter int WIN_LO = 12,
    parameter int WIN_W  = 12,
    parameter int N_MULT = 39
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      m_bit,
    input  logic                      m_valid,
    input  logic                      m_start,
    input  logic                      m_last,
    output logic                      done,
    output logic [N_MULT*WIN_W-1:0]   win
);

    localparam int TOP  = WIN_LO + WIN_W;
    localparam int SPAN = (MOD_W > TOP) ? MOD_W : TOP;
    localparam int CW   = $clog2(SPAN + 1);
    localparam logic [CW-1:0] TOP_M1 = CW'(TOP - 1);

    logic          s_bit [0:N_MULT];
    logic          b_bit [0:N_MULT];
    logic          v_bit [0:N_MULT];
    logic [CW-1:0] idx_v [0:N_MULT];
    logic          fe_bit, fe_vld;
    logic [CW-1:0] fe_idx;
    logic          tail_hit;
    logic          unused_sum, unused_b;

    assign s_bit[0] = 1'b0;
    assign b_bit[0] = fe_bit;
    assign v_bit[0] = fe_vld;
    assign idx_v[0] = fe_idx;
    assign tail_hit = v_bit[N_MULT] && (idx_v[N_MULT] == TOP_M1);

    negmul_feed #(.MOD_W(MOD_W), .TOP(TOP), .CW(CW)) feed_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_bit    (m_bit),
        .m_valid  (m_valid),
        .m_start  (m_start),
        .m_last   (m_last),
        .tail_hit (tail_hit),
        .bit_o    (fe_bit),
        .vld_o    (fe_vld),
        .idx_o    (fe_idx),
        .done_o   (done)
    );

    for (genvar j = 1; j <= N_MULT; j++) begin : g_stage
        logic st_sum, st_b;
        negmul_stage #(.CW(CW), .WIN_LO(WIN_LO), .WIN_W(WIN_W)) stage_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (m_start),
            .a_i   (s_bit[j-1]),
            .b_i   (b_bit[j-1]),
            .v_i   (v_bit[j-1]),
            .idx_i (idx_v[j-1]),
            .sum_o (st_sum),
            .b_o   (st_b),
            .v_o   (v_bit[j]),
            .idx_o (idx_v[j]),
            .win_o (win[(j-1)*WIN_W +: WIN_W])
        );
        if (j < N_MULT) begin : g_link
            assign s_bit[j] = st_sum;
            assign b_bit[j] = st_b;
        end else begin : g_end
            assign s_bit[j]   = 1'b0;
            assign b_bit[j]   = 1'b0;
            assign unused_sum = st_sum;
            assign unused_b   = st_b;
        end
    end

endmodule

// File: rtl/negmul_window_gen_chk.sv
module negmul_window_gen_chk #(
    parameter int N_MULT = 39,
    parameter int WIN_W  = 12,
    parameter int CW     = 5,
    parameter int TOP    = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    m_start,
    input logic                    done,
    input logic [N_MULT*WIN_W-1:0] win,
    input logic                    fe_vld,
    input logic [CW-1:0]           fe_idx
);

    p_start_drops_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_start |=> !done);

    p_start_clears_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_start |=> (win == '0));

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !m_start) |=> done);

    p_win_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !m_start) |=> $stable(win));

    // R5: no stream bit beyond the window top is sent into the chain
    p_stream_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fe_vld |-> (fe_idx < CW'(TOP)));

endmodule

bind negmul_window_gen negmul_window_gen_chk #(
    .N_MULT(N_MULT), .WIN_W(WIN_W), .CW(CW), .TOP(TOP)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_start (m_start),
    .done    (done),
    .win     (win),
    .fe_vld  (fe_vld),
    .fe_idx  (fe_idx)
);

// File: tb/negmul_window_gen_tb_top.sv
module negmul_window_gen_tb_top;

    localparam int MOD_W  = 28;
    localparam int WIN_LO = 12;
    localparam int WIN_W  = 12;
    localparam int N_MULT = 39;
    localparam int NV     = 6;

    // Stimulus table: modulus, length, idle cycles between bits, use m_last
    localparam logic [27:0] TV_M    [NV] = '{28'h0A5C3E1, 28'h0FFFFFF, 28'h000B3F7,
                                             28'h0800001, 28'hA123456, 28'h5123456};
    localparam int          TV_LEN  [NV] = '{24, 24, 16, 24, 28, 28};
    localparam int          TV_GAP  [NV] = '{0, 1, 0, 2, 1, 0};
    localparam int          TV_LAST [NV] = '{1, 1, 1, 1, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_bit = 1'b0, m_valid = 1'b0, m_start = 1'b0, m_last = 1'b0;
    logic done;
    logic [N_MULT*WIN_W-1:0] win;
    logic [N_MULT*WIN_W-1:0] snap;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    negmul_window_gen #(.MOD_W(MOD_W), .WIN_LO(WIN_LO), .WIN_W(WIN_W), .N_MULT(N_MULT)) dut_i (
        .clk(clk), .rst_n(rst_n), .m_bit(m_bit), .m_valid(m_valid),
        .m_start(m_start), .m_last(m_last), .done(done), .win(win)
    );

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
            report();
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_win(input logic [27:0] mm, input int j);
        longint p;
        p = -(longint'(j) * longint'(mm));
        p = p >>> WIN_LO;
        return p[11:0];
    endfunction

    task automatic pulse_start();
        @(negedge clk); m_start = 1'b1;
        @(negedge clk); m_start = 1'b0;
    endtask

    task automatic send_bits(input logic [27:0] mm, input int len, input int gap, input int use_last);
        for (int i = 0; i < len; i++) begin
            for (int g = 0; g < gap; g++) begin
                m_valid = 1'b0; m_bit = ~m_bit; m_last = 1'b1;   // junk on idle cycles (R3)
                @(negedge clk);
            end
            m_valid = 1'b1; m_bit = mm[i];
            m_last  = (use_last != 0) && (i == len - 1);
            @(negedge clk);
        end
        m_valid = 1'b0; m_last = 1'b0; m_bit = 1'b0;
    endtask

    task automatic wait_done();
        for (int w = 0; w < 400 && !done; w++) @(negedge clk);
        check("R6 done after load", 64'(done), 64'd1);
    endtask

    task automatic check_all(input string req, input logic [27:0] mm, input int len);
        logic [27:0] mv;
        mv = mm & ((28'd1 << len) - 28'd1);
        for (int j = 1; j <= N_MULT; j++)
            check(req, 64'(win[(j-1)*WIN_W +: WIN_W]), 64'(exp_win(mv, j)));
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 done at reset", 64'(done), 64'd0);
        check("R1 windows at reset", 64'(|win), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4/R5 table walk
        for (int v = 0; v < NV; v++) begin
            pulse_start();
            check("R7 start clears done", 64'(done), 64'd0);
            send_bits(TV_M[v], TV_LEN[v], TV_GAP[v], TV_LAST[v]);
            wait_done();
            if (TV_LEN[v] < WIN_LO + WIN_W) check_all("R4 padded modulus", TV_M[v], TV_LEN[v]);
            else if (TV_LEN[v] > WIN_LO + WIN_W) check_all("R5 high bits ignored", TV_M[v], TV_LEN[v]);
            else if (TV_GAP[v] != 0) check_all("R3 gapped stream", TV_M[v], TV_LEN[v]);
            else check_all("R2 window values", TV_M[v], TV_LEN[v]);
        end

        // R6: results hold while idle
        snap = win;
        repeat (25) @(negedge clk);
        check("R6 done held", 64'(done), 64'd1);
        check("R6 windows held", 64'(win == snap), 64'd1);

        // R8: inputs ignored while done
        send_bits(28'h0123ABC, 12, 0, 1);
        repeat (N_MULT + 4) @(negedge clk);
        check("R8 done unaffected", 64'(done), 64'd1);
        check("R8 windows unaffected", 64'(win == snap), 64'd1);

        // R7: abort partway through a load
        pulse_start();
        send_bits(28'h0FACE55, 10, 0, 0);
        repeat (5) @(negedge clk);
        m_start = 1'b1;
        @(negedge clk);
        m_start = 1'b0;
        check("R7 abort clears done", 64'(done), 64'd0);
        check("R7 abort clears windows", 64'(|win), 64'd0);
        send_bits(TV_M[0], 24, 0, 1);
        wait_done();
        check_all("R7 reload after abort", TV_M[0], 24);

        report();
    end

endmodule